// File: doc/BRIEF.md
# Burst Address Sequencer with Linear and Interleaved Orders

This block produces the access address for a short burst that begins at an externally supplied start address. A load command captures the full start address. Each later advance command moves the low address bits one step along the burst. The upper address bits keep the value captured at the load for the whole burst.

The block supports two step orders, chosen by a static select input. The linear order adds the running step count to the start bits and wraps within the burst. The interleaved order XORs the running step count into the start bits. A pause input freezes all state, so the previous address stays on the output. Advancing has no other qualifier: it depends only on the pause and load/advance inputs.

The low field is `BURST_W` bits wide. With the default of 2, a burst visits four addresses and then wraps back to its start.

Top module: `bsq_burst_seq`

## Requirements
- R1: After a synchronous active-high reset, `cur_addr` reads zero.
- R2: On a rising edge with `pause` low and `adv_sel` low, the whole `start_addr` is captured. From the next cycle, `cur_addr` equals that address, which is step 0 of a new burst.
- R3: On a rising edge with `pause` low and `adv_sel` high, the step count moves forward by one. Bits `[ADDR_W-1:BURST_W]` of `cur_addr` keep their loaded value.
- R4: With `order_ilv` low (linear order), the low `BURST_W` bits of `cur_addr` at step n equal (start + n) modulo 2^BURST_W. For example, a start of 01 gives 01, 10, 11, 00.
- R5: With `order_ilv` high (interleaved order), the low bits at step n equal start XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R6: The step count wraps and does not saturate. After 2^BURST_W advances, `cur_addr` is back at the start address and keeps cycling.
- R7: On a rising edge with `pause` high, no state changes, and `cur_addr` keeps its previous value whatever `adv_sel` and `start_addr` carry.
- R8: A load issued in the middle of a burst restarts the sequence at step 0 from the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pause | input | 1 | High: ignore this edge and hold all state |
| adv_sel | input | 1 | Low: load `start_addr`; high: advance one step |
| order_ilv | input | 1 | Low: linear order; high: interleaved order |
| start_addr | input | ADDR_W | Start address captured on a load |
| cur_addr | output | ADDR_W | Current access address |

## Verification
Every load, advance or pause takes effect at the rising edge where it is sampled. `cur_addr` shows the new value one register stage later, in the cycle that follows that edge; `order_ilv` acts combinationally on the stored state. The bench drives each command at a falling edge, waits for the next rising edge, and then reads `cur_addr` 1 ns later. Each check therefore sees exactly the result of the one command just issued. The sweep covers both orders, every start value of the low field and several upper-bit patterns, with pauses and mid-burst reloads placed in between.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } bsq_cmd_e;

    function automatic bsq_cmd_e bsq_decode(input logic pause, input logic adv_sel);
        if (pause)
            return CMD_HOLD;
        else if (!adv_sel)
            return CMD_LOAD;
        else
            return CMD_STEP;
    endfunction
endpackage

// File: rtl/bsq_step_ctr.sv
module bsq_step_ctr #(
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bsq_pkg::bsq_cmd_e cmd,
    output logic [CW-1:0]    step_q
);
    import bsq_pkg::*;

    typedef struct packed {
        logic [CW-1:0] step;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: st_d.step = '0;
            CMD_STEP: st_d.step = st_q.step + 1'b1;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign step_q = st_q.step;
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
    parameter int CW = 2
) (
    input  logic          order_ilv,
    input  logic [CW-1:0] base_low,
    input  logic [CW-1:0] step,
    output logic [CW-1:0] addr_low
);
    logic [CW-1:0] lin_low;
    logic [CW-1:0] ilv_low;

    always_comb begin
        lin_low = base_low + step;
        ilv_low = base_low ^ step;
        addr_low = order_ilv ? ilv_low : lin_low;
    end
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq #(
    parameter int ADDR_W  = 17,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pause,
    input  logic              adv_sel,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    import bsq_pkg::*;

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    bsq_cmd_e          cmd;
    logic [BURST_W-1:0] step_cnt;
    logic [BURST_W-1:0] low_bits;
    logic [ADDR_W-1:0] base_q;

    assign cmd = bsq_decode(pause, adv_sel);

    always_comb begin
        st_d = st_q;
        if (cmd == CMD_LOAD)
            st_d.base = start_addr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign base_q = st_q.base;

    bsq_step_ctr #(.CW(BURST_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .step_q (step_cnt)
    );

    bsq_order_map #(.CW(BURST_W)) u_map (
        .order_ilv (order_ilv),
        .base_low  (base_q[BURST_W-1:0]),
        .step      (step_cnt),
        .addr_low  (low_bits)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign cur_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
        end else begin : g_lo
            assign cur_addr = low_bits;
        end
    endgenerate
endmodule

// File: rtl/bsq_burst_seq_chk.sv
module bsq_burst_seq_chk #(
    parameter int ADDR_W  = 17,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pause,
    input logic              adv_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] base_q,
    input logic [BURST_W-1:0] step_cnt
);
    // R2: a load captures the whole start address and restarts at step 0
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        (!pause && !adv_sel) |=> (base_q == $past(start_addr) && step_cnt == '0));

    // R3: advancing keeps the upper address bits
    a_r3_upper_held: assert property (@(posedge clk) disable iff (rst)
        (!pause && adv_sel) |=> (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

    // R6: the step count wraps instead of saturating
    a_r6_step_wraps: assert property (@(posedge clk) disable iff (rst)
        (!pause && adv_sel) |=> (step_cnt == BURST_W'($past(step_cnt) + 1'b1)));

    // R7: a paused edge leaves all state alone
    a_r7_pause_holds: assert property (@(posedge clk) disable iff (rst)
        pause |=> ($stable(base_q) && $stable(step_cnt)));

    // R4 and R5: step 0 of either order is the start address itself
    a_r4_r5_step0_is_start: assert property (@(posedge clk) disable iff (rst)
        (step_cnt == '0) |-> (cur_addr == base_q));
endmodule

bind bsq_burst_seq bsq_burst_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pause      (pause),
    .adv_sel    (adv_sel),
    .start_addr (start_addr),
    .cur_addr   (cur_addr),
    .base_q     (base_q),
    .step_cnt   (step_cnt)
);

// File: tb/bsq_burst_seq_test.sv
module bsq_burst_seq_test;
    localparam int AW = 8;
    localparam int BW = 2;
    localparam int NSTEP = 1 << BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pause = 1'b0;
    logic          adv_sel = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] cur_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bsq_burst_seq #(.ADDR_W(AW), .BURST_W(BW)) uut (
        .clk        (clk),
        .rst        (rst),
        .pause      (pause),
        .adv_sel    (adv_sel),
        .order_ilv  (order_ilv),
        .start_addr (start_addr),
        .cur_addr   (cur_addr)
    );

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s, input int n, input logic ilv);
        logic [BW-1:0] lo;
        if (ilv)
            lo = s[BW-1:0] ^ BW'(n);
        else
            lo = s[BW-1:0] + BW'(n);
        return {s[AW-1:BW], lo};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (cur_addr !== exp) begin
            errors++;
            $display("FAIL %s: cur_addr=%h expected=%h", req, cur_addr, exp);
        end
    endtask

    task automatic cmd(input logic p, input logic adv, input logic [AW-1:0] a);
        @(negedge clk);
        pause = p;
        adv_sel = adv;
        start_addr = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;

        for (int o = 0; o < 2; o++) begin
            for (int hi = 0; hi < 3; hi++) begin
                for (int s = 0; s < NSTEP; s++) begin
                    logic [AW-1:0] sa;
                    sa = {AW'(hi * 37 + 5)} << BW | AW'(s);
                    @(negedge clk);
                    order_ilv = o[0];
                    cmd(1'b0, 1'b0, sa);
                    check("R2", sa);
                    for (int n = 1; n <= NSTEP + 1; n++) begin
                        cmd(1'b0, 1'b1, ~sa);
                        check(o ? "R5" : "R4", expect_addr(sa, n, o[0]));
                        if (n == NSTEP) check("R6", sa);
                        if (n == 2) begin
                            cmd(1'b1, 1'b0, ~sa);
                            check("R7", expect_addr(sa, 2, o[0]));
                            cmd(1'b1, 1'b1, ~sa);
                            check("R7", expect_addr(sa, 2, o[0]));
                        end
                        check("R3", {sa[AW-1:BW], cur_addr[BW-1:0]});
                    end
                    // R8: reload mid burst
                    cmd(1'b0, 1'b0, sa ^ AW'(8'hA6));
                    check("R8", sa ^ AW'(8'hA6));
                    cmd(1'b0, 1'b1, sa);
                    check("R8", expect_addr(sa ^ AW'(8'hA6), 1, o[0]));
                end
            end
        end

        // R1 again: reset mid burst
        cmd(1'b0, 1'b0, AW'(8'h5B));
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule